// File: doc/BRIEF.md
# Fan Tachometer Period Measurement Channel

This block measures the rotation period of one fan from its tachometer pulse train. The pin is brought into the clock domain through a flop synchroniser and then passes a debouncer with a selectable length. Period boundaries are chosen by an edge mode: falling edges only, rising edges only, or every transition. Between two boundaries a counter accumulates ticks from a power-of-four prescaler. The count is captured as the measured value, and an update pulse and a sticky completion flag are raised with it.

Each captured value is compared against a programmable threshold. The sense of the comparison can be inverted, so the same logic flags either a fan that is too slow (long period) or one that is too fast (short period). A sticky status bit records a hit and is cleared by a one-cycle clear pulse. The interrupt output is that bit gated by an enable. A fan that stops turning drives the counter to its ceiling, and the block then reports that ceiling as a measurement. Clearing the channel enable returns the measurement side to its idle state.

Top module: `tach_period_channel`

## Requirements
- R1: `raw_level` shows the level of `tach_in` two clock edges after the pin changes, through a two-flop synchroniser.
- R2: With debounce code c (`deb_sel`), N = 3 - c, so code 0 gives N=3, code 1 gives N=2, code 2 gives N=1 and code 3 gives N=0. `deb_level` takes a new level one edge after `raw_level` has differed from it on N+1 consecutive samples. A shorter excursion leaves `deb_level` unchanged.
- R3: Edge mode `edge_sel` = 0 bounds a period by falling debounced edges, 1 by rising edges, and 2 or 3 by every debounced transition.
- R4: With divisor code n (`div_sel`, values above 11 act as 11), a captured period of P clocks between two boundaries reads as floor(P / 4^n) in `meas_value`.
- R5: `full_meas` stays low until a second boundary closes a complete period after enabling. It then stays high while the channel is enabled.
- R6: `value_upd` pulses for one cycle with each new captured value: two captures for three periods in a single-edge mode, and five in both-edge mode.
- R7: When no boundary arrives, the counter stops at its all-ones maximum. Once a period has started, reaching that maximum captures it as a measurement, with one update pulse and no further pulses while the input stays quiet.
- R8: With `limit_inv` = 0, a captured value strictly greater than `threshold` sets `irq_status`. With `limit_inv` = 1, a value strictly less than `threshold` sets it. An equal value never sets it.
- R9: `irq` is high only when both `irq_status` and `irq_en` are high. A one-cycle `irq_clr` pulse clears `irq_status`.
- R10: One cycle after `ch_enable` goes low, `meas_value` is zero and `full_meas`, `value_upd` and `irq_status` are low.
- R11: During reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_in | input | 1 | Tachometer pin, asynchronous |
| ch_enable | input | 1 | Channel enable; low clears the measurement state |
| deb_sel | input | 2 | Debounce code, N = 3 - code stable samples beyond the first |
| edge_sel | input | 2 | 0 falling, 1 rising, 2/3 both edges |
| div_sel | input | DIV_SEL_W (4) | Prescaler exponent n, divide by 4^n |
| threshold | input | CNT_W (20) | Comparison limit |
| limit_inv | input | 1 | 0: flag above the limit, 1: flag below the limit |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | One-cycle pulse that clears irq_status |
| meas_value | output | CNT_W (20) | Last captured period count |
| value_upd | output | 1 | One-cycle pulse on each capture |
| full_meas | output | 1 | A complete period has been captured |
| raw_level | output | 1 | Synchronised pin level |
| deb_level | output | 1 | Debounced pin level |
| irq_status | output | 1 | Sticky limit-hit status |
| irq | output | 1 | irq_status gated by irq_en |

## Verification
The bench builds the channel with a 12-bit counter and threshold instead of 20 bits. This lowers the saturation point to 4095 ticks, so a stalled fan reaches the ceiling within a few thousand cycles, and that path is checked end to end together with its interrupt. The remaining parameters keep their defaults. Divisor codes 0 to 2 are used, so tick rates of 1, 4 and 16 clocks are exercised with periods that are and are not multiples of the divisor.

// File: rtl/tach_pkg.sv
package tach_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_ANY  = 2'd3
    } tach_edge_e;

    // extra stable samples required beyond the first differing one
    function automatic logic [1:0] deb_extra(input logic [1:0] code);
        return 2'd3 - code;
    endfunction

endpackage

// File: rtl/tach_conditioner.sv
module tach_conditioner #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] deb_sel,
    output logic       raw_level,
    output logic       deb_level,
    output logic       rise,
    output logic       fall
);
    import tach_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   deb;
        logic                   prev;
        logic [1:0]             run_len;
    } cond_t;

    cond_t st_d, st_q;
    logic  raw;
    logic [1:0] need;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        raw       = st_q.sync[SYNC_STAGES-1];
        need      = deb_extra(deb_sel);
        st_d.prev = st_q.deb;
        if (raw == st_q.deb) begin
            st_d.run_len = 2'd0;
        end else if (st_q.run_len >= need) begin
            st_d.deb     = raw;
            st_d.run_len = 2'd0;
        end else begin
            st_d.run_len = st_q.run_len + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_level = st_q.sync[SYNC_STAGES-1];
    assign deb_level = st_q.deb;
    assign rise      = st_q.deb & ~st_q.prev;
    assign fall      = ~st_q.deb & st_q.prev;

endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 2 * MAX_SEL;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t             st_d, st_q;
    logic [SEL_W-1:0] sel_c;
    logic [PRE_W-1:0] limit;

    always_comb begin
        sel_c = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
        limit = ~({PRE_W{1'b1}} << {sel_c, 1'b0});
        tick  = run && (st_q.cnt == limit);
        st_d  = st_q;
        if (!run || restart || tick) st_d.cnt = '0;
        else                         st_d.cnt = st_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bound,
    input  logic             tick,
    output logic [CNT_W-1:0] value,
    output logic             upd,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] value;
        logic             armed;
        logic             upd;
        logic             full;
    } meter_t;

    meter_t           st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             stall;

    always_comb begin
        cnt_inc  = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + CNT_W'(tick);
        stall    = st_q.armed && tick && (st_q.cnt == CNT_NEAR) && !bound;
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (!run) begin
            st_d = '0;
        end else if (bound) begin
            if (st_q.armed) begin
                st_d.value = cnt_inc;
                st_d.upd   = 1'b1;
                st_d.full  = 1'b1;
            end
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (stall) begin
            st_d.value = CNT_MAX;
            st_d.upd   = 1'b1;
            st_d.full  = 1'b1;
            st_d.cnt   = CNT_MAX;
        end else begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.value;
    assign upd   = st_q.upd;
    assign full  = st_q.full;

endmodule

// File: rtl/tach_period_channel.sv
module tach_period_channel #(
    parameter int CNT_W       = 20,
    parameter int DIV_SEL_W   = 4,
    parameter int DIV_SEL_MAX = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tach_in,
    input  logic                 ch_enable,
    input  logic [1:0]           deb_sel,
    input  logic [1:0]           edge_sel,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0]     threshold,
    input  logic                 limit_inv,
    input  logic                 irq_en,
    input  logic                 irq_clr,
    output logic [CNT_W-1:0]     meas_value,
    output logic                 value_upd,
    output logic                 full_meas,
    output logic                 raw_level,
    output logic                 deb_level,
    output logic                 irq_status,
    output logic                 irq
);
    import tach_pkg::*;

    typedef struct packed {
        logic status;
    } irq_t;

    logic rise, fall, bound, tick, hit;
    irq_t irq_d, irq_q;

    tach_conditioner #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (tach_in),
        .deb_sel   (deb_sel),
        .raw_level (raw_level),
        .deb_level (deb_level),
        .rise      (rise),
        .fall      (fall)
    );

    always_comb begin
        unique case (tach_edge_e'(edge_sel))
            EDGE_FALL: bound = fall;
            EDGE_RISE: bound = rise;
            default:   bound = rise | fall;
        endcase
    end

    tach_prescaler #(.SEL_W(DIV_SEL_W), .MAX_SEL(DIV_SEL_MAX)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ch_enable),
        .restart (bound),
        .sel     (div_sel),
        .tick    (tick)
    );

    tach_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ch_enable),
        .bound (bound),
        .tick  (tick),
        .value (meas_value),
        .upd   (value_upd),
        .full  (full_meas)
    );

    always_comb begin
        hit   = limit_inv ? (meas_value < threshold) : (meas_value > threshold);
        irq_d = irq_q;
        if (!ch_enable)             irq_d.status = 1'b0;
        else if (value_upd && hit)  irq_d.status = 1'b1;
        else if (irq_clr)           irq_d.status = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign irq_status = irq_q.status;
    assign irq        = irq_q.status & irq_en;

endmodule

// File: rtl/tach_channel_checker.sv
module tach_channel_checker #(
    parameter int CNT_W     = 20,
    parameter int DIV_SEL_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tach_in,
    input logic                 ch_enable,
    input logic [1:0]           deb_sel,
    input logic [1:0]           edge_sel,
    input logic [DIV_SEL_W-1:0] div_sel,
    input logic [CNT_W-1:0]     threshold,
    input logic                 limit_inv,
    input logic                 irq_en,
    input logic                 irq_clr,
    input logic [CNT_W-1:0]     meas_value,
    input logic                 value_upd,
    input logic                 full_meas,
    input logic                 raw_level,
    input logic                 deb_level,
    input logic                 irq_status,
    input logic                 irq
);
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_status && irq_en));

    a_r5_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (full_meas && ch_enable) |=> full_meas);

    a_r6_update_marks_full: assert property (@(posedge clk) disable iff (!rst_n)
        value_upd |-> full_meas);

    a_r6_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!value_upd && $past(ch_enable)) |-> $stable(meas_value));

    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_enable |=> (meas_value == '0 && !full_meas && !value_upd && !irq_status));

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !irq_clr && ch_enable) |=> irq_status);

endmodule

bind tach_period_channel tach_channel_checker #(.CNT_W(CNT_W), .DIV_SEL_W(DIV_SEL_W)) u_chk (.*);

// File: tb/tb_tach_period_channel.sv
module tb_tach_period_channel;

    localparam int CNT_W = 12;
    localparam int DSW   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tach_in = 1'b1;
    logic             ch_enable = 1'b0;
    logic [1:0]       deb_sel = 2'd3;
    logic [1:0]       edge_sel = 2'd0;
    logic [DSW-1:0]   div_sel = '0;
    logic [CNT_W-1:0] threshold = '0;
    logic             limit_inv = 1'b0;
    logic             irq_en = 1'b0;
    logic             irq_clr = 1'b0;
    logic [CNT_W-1:0] meas_value;
    logic             value_upd, full_meas, raw_level, deb_level, irq_status, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int upd_total = 0;
    int deb_toggles = 0;
    logic deb_last = 1'b0;

    always #2 clk = ~clk;

    tach_period_channel #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .ch_enable(ch_enable),
        .deb_sel(deb_sel), .edge_sel(edge_sel), .div_sel(div_sel),
        .threshold(threshold), .limit_inv(limit_inv), .irq_en(irq_en),
        .irq_clr(irq_clr), .meas_value(meas_value), .value_upd(value_upd),
        .full_meas(full_meas), .raw_level(raw_level), .deb_level(deb_level),
        .irq_status(irq_status), .irq(irq)
    );

    always @(negedge clk) begin
        if (value_upd) upd_total <= upd_total + 1;
        if (deb_level !== deb_last) deb_toggles <= deb_toggles + 1;
        deb_last <= deb_level;
    end

    // edge(2) div(4) deb(2) lo(12) hi(12) expected(16)
    localparam int NV = 8;
    localparam logic [47:0] VEC [NV] = '{
        {2'd0, 4'd0, 2'd3, 12'd7,  12'd13, 16'd20},
        {2'd1, 4'd0, 2'd3, 12'd30, 12'd10, 16'd40},
        {2'd2, 4'd0, 2'd3, 12'd9,  12'd25, 16'd9},
        {2'd0, 4'd1, 2'd0, 12'd21, 12'd30, 16'd12},
        {2'd1, 4'd1, 2'd1, 12'd16, 12'd16, 16'd8},
        {2'd2, 4'd2, 2'd3, 12'd70, 12'd12, 16'd4},
        {2'd0, 4'd2, 2'd2, 12'd40, 12'd40, 16'd5},
        {2'd3, 4'd0, 2'd3, 12'd12, 12'd20, 16'd12}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int e, input int d, input int db,
                         input int thr, input logic inv, input logic ien);
        ch_enable = 1'b0;
        tach_in   = 1'b1;
        cycles(12);
        edge_sel  = 2'(e);
        div_sel   = DSW'(d);
        deb_sel   = 2'(db);
        threshold = CNT_W'(thr);
        limit_inv = inv;
        irq_en    = ien;
        ch_enable = 1'b1;
        cycles(2);
    endtask

    task automatic periods(input int lo, input int hi, input int reps);
        for (int r = 0; r < reps; r++) begin
            tach_in = 1'b0;
            cycles(lo);
            tach_in = 1'b1;
            cycles(hi);
        end
    endtask

    task automatic deb_latency(input int code);
        int n;
        n = 3 - code;
        deb_sel = 2'(code);
        tach_in = 1'b1;
        cycles(12);
        tach_in = 1'b0;
        for (int i = 1; i <= n + 3; i++) begin
            cycles(1);
            if (i == 1)     check("R1 raw before", raw_level, 1);
            if (i == 2)     check("R1 raw after", raw_level, 0);
            if (i == n + 2) check("R2 deb before", deb_level, 1);
            if (i == n + 3) check("R2 deb after", deb_level, 0);
        end
        tach_in = 1'b1;
        cycles(12);
    endtask

    task automatic glitch(input int code, input int width, input int exp_tog);
        int base;
        deb_sel = 2'(code);
        tach_in = 1'b1;
        cycles(12);
        base = deb_toggles;
        tach_in = 1'b0;
        cycles(width);
        tach_in = 1'b1;
        cycles(15);
        check("R2 glitch toggles", deb_toggles - base, exp_tog);
    endtask

    task automatic irq_case(input int thr, input logic inv, input int exp_st);
        setup(0, 0, 3, thr, inv, 1'b0);
        periods(10, 10, 3);
        check("R4 value for limit test", meas_value, 20);
        check("R8 limit status", irq_status, exp_st);
    endtask

    initial begin : watchdog
        cycles(150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int base;
        cycles(3);
        // R11: reset state
        check("R11 meas_value", meas_value, 0);
        check("R11 value_upd", value_upd, 0);
        check("R11 full_meas", full_meas, 0);
        check("R11 raw_level", raw_level, 0);
        check("R11 deb_level", deb_level, 0);
        check("R11 irq_status", irq_status, 0);
        check("R11 irq", irq, 0);
        rst_n = 1'b1;
        cycles(10);

        // R3 R4 R6: vector table
        for (int v = 0; v < NV; v++) begin
            logic [47:0] w;
            w = VEC[v];
            setup(int'(w[47:46]), int'(w[45:42]), int'(w[41:40]), 0, 1'b0, 1'b0);
            base = upd_total;
            periods(int'(w[39:28]), int'(w[27:16]), 3);
            check($sformatf("R3/R4 vector %0d value", v), meas_value, int'(w[15:0]));
            check($sformatf("R5 vector %0d full", v), full_meas, 1);
            check($sformatf("R6 vector %0d updates", v), upd_total - base,
                  (w[47:46] == 2'd0 || w[47:46] == 2'd1) ? 2 : 5);
        end

        // R1 R2: latency through synchroniser and debouncer
        deb_latency(3);
        deb_latency(0);
        // R2: glitch filtering at boundaries
        glitch(0, 3, 0);
        glitch(0, 4, 2);
        glitch(2, 1, 0);
        glitch(2, 2, 2);

        // R5: one boundary does not complete a period
        setup(0, 0, 3, 0, 1'b0, 1'b0);
        base = upd_total;
        tach_in = 1'b0;
        cycles(10);
        tach_in = 1'b1;
        cycles(10);
        check("R5 full after one edge", full_meas, 0);
        check("R6 no update after one edge", upd_total - base, 0);
        tach_in = 1'b0;
        cycles(10);
        check("R5 full after two edges", full_meas, 1);

        // R8 R9: threshold comparison and interrupt gating
        irq_case(15, 1'b0, 1);
        check("R9 irq masked", irq, 0);
        irq_en = 1'b1;
        cycles(1);
        check("R9 irq enabled", irq, 1);
        irq_clr = 1'b1;
        cycles(1);
        irq_clr = 1'b0;
        cycles(1);
        check("R9 status cleared", irq_status, 0);
        check("R9 irq cleared", irq, 0);
        irq_case(25, 1'b0, 0);
        irq_case(25, 1'b1, 1);
        irq_case(20, 1'b1, 0);
        irq_case(20, 1'b0, 0);

        // R7: stalled input saturates the count
        setup(0, 0, 3, 100, 1'b0, 1'b0);
        base = upd_total;
        tach_in = 1'b0;
        cycles(4200);
        check("R7 saturated value", meas_value, 4095);
        check("R7 full on stall", full_meas, 1);
        check("R7 single update", upd_total - base, 1);
        check("R8 status on stall", irq_status, 1);
        cycles(200);
        check("R7 no repeat update", upd_total - base, 1);

        // R10: disabling clears measurement state
        ch_enable = 1'b0;
        cycles(1);
        check("R10 value cleared", meas_value, 0);
        check("R10 full cleared", full_meas, 0);
        check("R10 upd low", value_upd, 0);
        check("R10 status cleared", irq_status, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule